// File: doc/BRIEF.md
# Misroute-Limited Adaptive Output Port Selector

This block picks the output port for one packet in a fully adaptive router that may route packets away from the shortest path. Each cycle it is given the set of output ports that bring the packet nearer to its destination ("productive" ports), the free/busy state of every output, the input port the packet arrived on, a flag telling whether the packet has reached its destination, and the count of detours the packet has already taken, as carried in its header. It returns one port, a flag that the choice is a detour, and the updated detour count to write back into the header.

The block always tries a free productive port first. When every productive port is busy, the packet may take a detour through a non-productive port. A detour is allowed only while the packet's detour count is below a limit, and never through the port the packet came in on. The limit bounds how far a packet can wander, so a packet cannot circle the network forever. A packet at its destination always goes to the local ejection port. When several ports of the same class are free, a rotating pointer shares the choices among them.

The request side is a valid/ready handshake. The requester holds `req_valid` and all request fields steady until `req_ready` is high. `req_ready` reflects only the current fields and the current output free mask. A busy output acts as back-pressure: the packet waits, its count is not changed, and nothing is granted. A transfer happens in a cycle where both `req_valid` and `req_ready` are high. `grant_valid` marks that cycle, and the pointer moves at the following clock edge.

Top module: `misroute_port_sel`

## Requirements
- R1: After reset the rotating pointer is at port 0, so the first grant goes to the lowest-numbered eligible free port.
- R2: When the packet is not at its destination and at least one productive port (bit set in `prod_mask`) is free and is not the arrival port, the grant is a productive port, `grant_misroute` is 0 and `mis_cnt_out` equals `mis_cnt_in`.
- R3: When no productive port is eligible and `mis_cnt_in` is below `MIS_LIMIT` (default 3), a free non-productive port is granted, `grant_misroute` is 1 and `mis_cnt_out` equals `mis_cnt_in` + 1.
- R4: When not at the destination, the port equal to `in_port` is never granted, even if it is free.
- R5: When `mis_cnt_in` is at or above `MIS_LIMIT`, no non-productive port is granted. With no productive port free, `grant_valid` and `req_ready` are 0.
- R6: When no eligible port is free, `req_ready` and `grant_valid` are 0 and `mis_cnt_out` equals `mis_cnt_in`. The same holds for the count whenever `req_valid` is 0.
- R7: With `at_dest` high, only the local port (index `LOCAL_PORT`, default 0) is granted, whatever the count and productive mask. The count is unchanged, and the request waits while the local port is busy.
- R8: After each transfer the pointer moves to the granted index plus one, wrapping at `NUM_PORTS`. The search starts at the pointer and wraps. With no transfer the pointer holds.
- R9: When not at the destination, the local port is never granted.
- R10: `grant_onehot` has exactly bit `grant_port` set when `grant_valid` is 1, and is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A packet header is presented |
| req_ready | output | 1 | An eligible free port exists for the presented fields |
| prod_mask | input | NUM_PORTS | Ports that move the packet nearer its destination |
| at_dest | input | 1 | Packet has reached its destination router |
| in_port | input | $clog2(NUM_PORTS) | Port the packet arrived on |
| mis_cnt_in | input | MIS_W | Detours taken so far, from the header |
| port_free | input | NUM_PORTS | Output availability, 1 = free |
| grant_valid | output | 1 | Transfer this cycle (req_valid and req_ready) |
| grant_port | output | $clog2(NUM_PORTS) | Index of the chosen port |
| grant_onehot | output | NUM_PORTS | One-hot form of the chosen port |
| grant_misroute | output | 1 | The granted port is a detour |
| mis_cnt_out | output | MIS_W | Detour count to write back to the header |

## Verification
The bench covers the following cases:
- A busy productive port whose only free neighbour is the arrival port. A selector that ignores the arrival port would send the packet straight back.
- Packets exactly at the detour limit and one below it. An off-by-one compare would either grant one detour too many or stall packets that still have a detour left.
- Destination packets with a saturated count and busy local port. A broken design would eject through another port or bump the count.
- Rotation across several grants, including a wrap past the top index and a cycle with `req_valid` low. A faulty pointer would repeat a port or drift while idle.

// File: rtl/msel_pkg.sv
package msel_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_EJECT  = 2'd1,
    ROUTE_PROD   = 2'd2,
    ROUTE_DETOUR = 2'd3
  } route_kind_e;

  // Sum of two indices modulo a port count.
  function automatic int wrap_add(input int base, input int off, input int modulus);
    int s;
    s = base + off;
    if (s >= modulus) s = s - modulus;
    return s;
  endfunction

endpackage

// File: rtl/msel_classify.sv
module msel_classify #(
  parameter int NUM_PORTS  = 5,
  parameter int LOCAL_PORT = 0,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] prod_mask,
  input  logic [NUM_PORTS-1:0] port_free,
  input  logic [PW-1:0]        in_port,
  input  logic                 at_dest,
  output logic [NUM_PORTS-1:0] eject_cand,
  output logic [NUM_PORTS-1:0] prod_cand,
  output logic [NUM_PORTS-1:0] detour_cand
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    localparam logic [PW-1:0] IDX = PW'(i);
    localparam bit IS_LOCAL = (i == LOCAL_PORT);
    logic arrival;
    logic transit_ok;

    assign arrival    = (in_port == IDX);
    assign transit_ok = !at_dest && !IS_LOCAL && !arrival && port_free[i];

    assign eject_cand[i]  = at_dest && IS_LOCAL && port_free[i];
    assign prod_cand[i]   = transit_ok && prod_mask[i];
    assign detour_cand[i] = transit_ok && !prod_mask[i];
  end

endmodule

// File: rtl/msel_rr_pick.sv
module msel_rr_pick #(
  parameter int NUM_PORTS = 5,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] cand,
  input  logic [PW-1:0]        start,
  output logic                 found,
  output logic [PW-1:0]        idx
);
  import msel_pkg::*;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (!found && cand[wrap_add(int'(start), k, NUM_PORTS)]) begin
        found = 1'b1;
        idx   = PW'(wrap_add(int'(start), k, NUM_PORTS));
      end
    end
  end

endmodule

// File: rtl/msel_rr_ptr.sv
module msel_rr_ptr #(
  parameter int NUM_PORTS = 5,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [PW-1:0] last_idx,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] TOP = PW'(NUM_PORTS - 1);

  logic [PW-1:0] next_ptr;

  assign next_ptr = (last_idx == TOP) ? '0 : last_idx + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= next_ptr;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOP); // R8

endmodule

// File: rtl/misroute_port_sel.sv
module misroute_port_sel #(
  parameter int NUM_PORTS  = 5,
  parameter int LOCAL_PORT = 0,
  parameter int MIS_W      = 3,
  parameter int MIS_LIMIT  = 3,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [NUM_PORTS-1:0] prod_mask,
  input  logic                 at_dest,
  input  logic [PW-1:0]        in_port,
  input  logic [MIS_W-1:0]     mis_cnt_in,
  input  logic [NUM_PORTS-1:0] port_free,
  output logic                 grant_valid,
  output logic [PW-1:0]        grant_port,
  output logic [NUM_PORTS-1:0] grant_onehot,
  output logic                 grant_misroute,
  output logic [MIS_W-1:0]     mis_cnt_out
);
  import msel_pkg::*;

  localparam int            NCLS    = 2;
  localparam logic [PW-1:0] LOCAL_V = PW'(LOCAL_PORT);
  localparam logic [MIS_W-1:0] LIMIT_V = MIS_W'(MIS_LIMIT);

  logic [NUM_PORTS-1:0] eject_cand, prod_cand, detour_cand;
  logic [NUM_PORTS-1:0] cls_cand [NCLS];
  logic                 cls_found[NCLS];
  logic [PW-1:0]        cls_idx  [NCLS];
  logic [PW-1:0]        ptr;
  logic                 budget_ok;
  route_kind_e          kind;

  msel_classify #(.NUM_PORTS(NUM_PORTS), .LOCAL_PORT(LOCAL_PORT)) u_classify (
    .prod_mask  (prod_mask),
    .port_free  (port_free),
    .in_port    (in_port),
    .at_dest    (at_dest),
    .eject_cand (eject_cand),
    .prod_cand  (prod_cand),
    .detour_cand(detour_cand)
  );

  assign cls_cand[0] = prod_cand;
  assign cls_cand[1] = detour_cand;

  // One rotating picker per port class; both share the pointer.
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    msel_rr_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
      .cand (cls_cand[c]),
      .start(ptr),
      .found(cls_found[c]),
      .idx  (cls_idx[c])
    );
  end

  assign budget_ok = (mis_cnt_in < LIMIT_V);

  always_comb begin
    if (at_dest)               kind = (|eject_cand) ? ROUTE_EJECT : ROUTE_NONE;
    else if (cls_found[0])     kind = ROUTE_PROD;
    else if (budget_ok && cls_found[1]) kind = ROUTE_DETOUR;
    else                       kind = ROUTE_NONE;
  end

  always_comb begin
    unique case (kind)
      ROUTE_EJECT:  grant_port = LOCAL_V;
      ROUTE_PROD:   grant_port = cls_idx[0];
      ROUTE_DETOUR: grant_port = cls_idx[1];
      default:      grant_port = '0;
    endcase
  end

  assign req_ready      = (kind != ROUTE_NONE);
  assign grant_valid    = req_valid && req_ready;
  assign grant_misroute = grant_valid && (kind == ROUTE_DETOUR);
  assign mis_cnt_out    = grant_misroute ? mis_cnt_in + MIS_W'(1) : mis_cnt_in;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_onehot
    assign grant_onehot[p] = grant_valid && (grant_port == PW'(p));
  end

  msel_rr_ptr #(.NUM_PORTS(NUM_PORTS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (grant_valid),
    .last_idx(grant_port),
    .ptr     (ptr)
  );

  // Port-level checks
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant_onehot) == 1 && (grant_onehot & port_free) != '0)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant_onehot == '0); // R10
  AST_NO_UTURN: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !at_dest) |-> grant_port != in_port); // R4
  AST_NO_LOCAL_TRANSIT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !at_dest) |-> grant_port != LOCAL_V); // R9
  AST_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_misroute |-> mis_cnt_in < LIMIT_V); // R5
  AST_DETOUR_NOT_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_misroute |-> (prod_mask[grant_port] == 1'b0 && prod_cand == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_misroute |-> mis_cnt_out == mis_cnt_in); // R6
  AST_DEST_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && at_dest) |-> (grant_port == LOCAL_V && !grant_misroute)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> $stable(ptr)); // R8

endmodule

// File: tb/misroute_port_sel_tb.sv
`timescale 1ns/1ps
module misroute_port_sel_tb;

  localparam int NP = 5;
  localparam int PW = 3;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [NP-1:0] prod_mask = '0;
  logic          at_dest = 1'b0;
  logic [PW-1:0] in_port = '0;
  logic [MW-1:0] mis_cnt_in = '0;
  logic [NP-1:0] port_free = '0;
  logic          grant_valid;
  logic [PW-1:0] grant_port;
  logic [NP-1:0] grant_onehot;
  logic          grant_misroute;
  logic [MW-1:0] mis_cnt_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  misroute_port_sel u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .prod_mask(prod_mask), .at_dest(at_dest), .in_port(in_port),
    .mis_cnt_in(mis_cnt_in), .port_free(port_free), .grant_valid(grant_valid),
    .grant_port(grant_port), .grant_onehot(grant_onehot),
    .grant_misroute(grant_misroute), .mis_cnt_out(mis_cnt_out)
  );

  // Drive one request after a falling edge, sample 1 ns later,
  // then let the next rising edge update the pointer.
  task automatic step(input string tag, input bit v, input logic [NP-1:0] pm,
                      input bit dst, input int inp, input int cnt,
                      input logic [NP-1:0] fr, input bit e_ok, input int e_port,
                      input bit e_mis, input int e_cnt);
    @(negedge clk);
    req_valid = v; prod_mask = pm; at_dest = dst; in_port = PW'(inp);
    mis_cnt_in = MW'(cnt); port_free = fr;
    #1;
    n_tests++;
    if (req_ready !== e_ok || grant_valid !== (e_ok && v)) begin
      n_fail++;
      $display("FAIL %s ready/valid: got %0b/%0b expected %0b/%0b", tag,
               req_ready, grant_valid, e_ok, e_ok && v);
    end else if (e_ok && v && (grant_port !== PW'(e_port) ||
             grant_onehot !== NP'(1 << e_port) || grant_misroute !== e_mis)) begin
      n_fail++;
      $display("FAIL %s port/onehot/mis: got %0d/%b/%0b expected %0d/%b/%0b", tag,
               grant_port, grant_onehot, grant_misroute, e_port,
               NP'(1 << e_port), e_mis);
    end else if (!(e_ok && v) && grant_onehot !== '0) begin
      n_fail++;
      $display("FAIL %s idle onehot: got %b expected 0", tag, grant_onehot);
    end else if (mis_cnt_out !== MW'(e_cnt)) begin
      n_fail++;
      $display("FAIL %s count: got %0d expected %0d", tag, mis_cnt_out, e_cnt);
    end
  endtask

  task automatic t_reset_and_rotation();
    // R1: pointer at 0, candidates 1..4 -> port 1
    step("R1 first grant", 1, 5'b11110, 0, 0, 0, 5'b11111, 1, 1, 0, 0);
    step("R8 advance to 2", 1, 5'b11110, 0, 0, 0, 5'b11111, 1, 2, 0, 0);
    step("R8 wrap search", 1, 5'b00010, 0, 0, 0, 5'b11111, 1, 1, 0, 0);
    step("R6 idle hold", 0, 5'b11110, 0, 0, 1, 5'b11111, 1, 0, 0, 1);
    step("R8 held pointer", 1, 5'b11110, 0, 0, 0, 5'b11111, 1, 2, 0, 0);
  endtask

  task automatic t_productive_first();
    // R2: productive port 2 free, detours also free
    step("R2 productive wins", 1, 5'b00100, 0, 1, 1, 5'b11111, 1, 2, 0, 1);
  endtask

  task automatic t_detour();
    // R3: port 2 busy, arrival 1 -> detour among 3,4, ptr=3
    step("R3 detour", 1, 5'b00100, 0, 1, 1, 5'b11011, 1, 3, 1, 2);
  endtask

  task automatic t_uturn_and_local();
    // R4/R9: only arrival port 3 and local free -> wait
    step("R4 R9 no uturn or local", 1, 5'b00010, 0, 3, 0, 5'b01001, 0, 0, 0, 0);
  endtask

  task automatic t_limit();
    step("R5 at limit waits", 1, 5'b00010, 0, 2, 3, 5'b11101, 0, 0, 0, 3);
    // ptr=4 still; one below limit -> detour to 4
    step("R5 below limit detours", 1, 5'b00010, 0, 2, 2, 5'b11101, 1, 4, 1, 3);
  endtask

  task automatic t_destination();
    // R7: ptr=0; counter above limit ignored
    step("R7 eject", 1, 5'b00000, 1, 0, 5, 5'b11111, 1, 0, 0, 5);
    step("R7 local busy waits", 1, 5'b11110, 1, 2, 1, 5'b11110, 0, 0, 0, 1);
  endtask

  task automatic t_rotation_wrap();
    // ptr=1 after eject; productive {2,4}
    step("R8 rot a", 1, 5'b10100, 0, 0, 0, 5'b11111, 1, 2, 0, 0);
    step("R8 rot b", 1, 5'b10100, 0, 0, 0, 5'b11111, 1, 4, 0, 0);
    step("R8 rot wrap", 1, 5'b10100, 0, 0, 0, 5'b11111, 1, 2, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (req_ready !== 1'b0 || grant_valid !== 1'b0 || grant_onehot !== '0) begin
      n_fail++;
      $display("FAIL R1 reset idle: got %0b/%0b/%b expected 0/0/0",
               req_ready, grant_valid, grant_onehot);
    end
    rst_n = 1'b1;
    t_reset_and_rotation();
    t_productive_first();
    t_detour();
    t_uturn_and_local();
    t_limit();
    t_destination();
    t_rotation_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule